// File: doc/BRIEF.md
# Countdown Vertical and Horizontal Deflection Timing Generator

This block derives the deflection timing for a 525-line, 60 Hz interlaced picture from one clock running at a fixed multiple of the line rate (32 times by default, roughly 503 kHz). A line divider makes a square-wave horizontal drive and a tick at every half-line. A field counter counts those half-lines, 525 per field, so a field lasts 262.5 lines and two fields make a full 525-line frame. A decoder takes the field count and produces an active-low vertical drive pulse 10 lines wide and a vertical blanking pulse 17 lines wide.

Separated vertical sync arrives on one input. The spacing between its rising edges is measured in half-lines. Only edges whose spacing matches a field rate between about 56 Hz and 64 Hz count as good. A run of good edges brings the generator into lock. While it is locked, each good edge restarts the field count. Otherwise the field counter free-runs. A 5-bit position value delays the vertical pulses by whole lines. A service input parks the vertical drive at its inactive level.

Top module: `countdown_sync_gen`

## Requirements
- R1: `h_drive` has a period of CLK_PER_LINE clocks and is high for the first CLK_PER_LINE/2 clocks of each period, counted from the end of reset.
- R2: The field count advances once per half-line (every CLK_PER_LINE/2 clocks) and wraps after 525 half-lines. With no sync, the falling edges of `v_drive_n` are 525·CLK_PER_LINE/2 clocks apart.
- R3: A rising edge of `vsync_in` is good when the number of half-line ticks since the previous edge, timeout or reset lies between 492 and 562 inclusive. Any other edge is bad. Every edge restarts that count from zero.
- R4: When a half-line tick arrives with the count already at 562 and no edge in that cycle, the tick counts as a bad event (a missing sync) and the count restarts.
- R5: `unlocked` goes low on the 4th consecutive good edge and goes high on the 4th consecutive bad event. A good edge clears the bad run and a bad event clears the good run.
- R6: A good edge seen while locked sets the field count to zero in the next cycle. With `vpos` at 0, `v_drive_n` is then low and `v_blank` high.
- R7: Let s be the shifted field count. `v_drive_n` is low while s < 20, which is 10 lines. `v_blank` is high while s < 34, which is 17 lines.
- R8: s = (field count − 2·`vpos`) mod 525. This delays both pulses by `vpos` lines, from 0 to 31.
- R9: While `service` is high, `v_drive_n` stays high. `h_drive`, `v_blank` and `unlocked` are unaffected.
- R10: A bad edge never changes the field count, whether the generator is locked or not.
- R11: After reset, `h_drive` = 1, `v_drive_n` = 0, `v_blank` = 1 and `unlocked` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at CLK_PER_LINE times the line rate |
| rst | input | 1 | Synchronous reset, active high |
| vsync_in | input | 1 | Separated vertical sync, rising edge used |
| vpos | input | POS_W | Vertical position delay in lines |
| service | input | 1 | Holds the vertical drive inactive |
| h_drive | output | 1 | Horizontal drive, 50% duty |
| v_drive_n | output | 1 | Vertical drive, active low |
| v_blank | output | 1 | Vertical blanking, active high |
| unlocked | output | 1 | High when not locked to the incoming sync |

## Verification
A field count that drifts or wraps at the wrong value first shows up at `v_drive_n` and `v_blank` at the next pulse. That can be up to one field later, so the model compares the vertical outputs on every clock rather than only at pulse edges. A wrong edge classification or run count shows up only at `unlocked`, one cycle after the 4th event, or as a pulse that fails to snap to the sync in the cycle after a good edge. For that reason, edge spacings are sent close to both window limits and just outside them. The horizontal divider shows a fault within one line.

// File: rtl/sgen_pkg.sv
package sgen_pkg;
    localparam int unsigned DEF_CLK_PER_LINE  = 32;
    localparam int unsigned DEF_FIELD_HL      = 525;
    localparam int unsigned DEF_VPULSE_LINES  = 10;
    localparam int unsigned DEF_VBLANK_LINES  = 17;
    localparam int unsigned DEF_POS_W         = 5;
    localparam int unsigned DEF_WIN_MIN_HL    = 492;
    localparam int unsigned DEF_WIN_MAX_HL    = 562;
    localparam int unsigned DEF_LOCK_RUN      = 4;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_GOOD = 2'd1,
        EV_BAD  = 2'd2
    } sync_ev_e;

    typedef struct packed {
        logic h_hi;
        logic hl_tick;
    } line_sig_t;

    function automatic logic run_next_full(input int unsigned run, input int unsigned limit);
        return (run + 1) >= limit;
    endfunction
endpackage

// File: rtl/sg_line_div.sv
module sg_line_div
    import sgen_pkg::*;
#(
    parameter int unsigned CLK_PER_LINE = DEF_CLK_PER_LINE
) (
    input  logic      clk,
    input  logic      rst,
    output line_sig_t line_o
);
    localparam int unsigned HALF = CLK_PER_LINE / 2;
    localparam int unsigned CW   = $clog2(CLK_PER_LINE);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (cnt == CW'(CLK_PER_LINE - 1))
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    always_comb begin
        line_o.h_hi    = (cnt < CW'(HALF));
        line_o.hl_tick = (cnt == CW'(HALF - 1)) || (cnt == CW'(CLK_PER_LINE - 1));
    end

    // Half-line ticks never come on back-to-back clocks
    assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        line_o.hl_tick |=> !line_o.hl_tick);

    // The drive level changes only after a half-line tick
    assert_h_steady_R1: assert property (@(posedge clk) disable iff (rst)
        !$past(line_o.hl_tick) |-> $stable(line_o.h_hi));
endmodule

// File: rtl/sg_sync_qual.sv
module sg_sync_qual
    import sgen_pkg::*;
#(
    parameter int unsigned WIN_MIN_HL = DEF_WIN_MIN_HL,
    parameter int unsigned WIN_MAX_HL = DEF_WIN_MAX_HL,
    parameter int unsigned LOCK_RUN   = DEF_LOCK_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic vsync_in,
    input  logic hl_tick,
    output logic locked,
    output logic sync_hit
);
    localparam int unsigned PW = $clog2(WIN_MAX_HL + 1);
    localparam int unsigned LW = $clog2(LOCK_RUN + 1);

    logic          vs_q;
    logic [PW-1:0] span;
    logic [LW-1:0] good_run;
    logic [LW-1:0] bad_run;
    logic          rise;
    logic          in_win;
    logic          timeout;
    sync_ev_e      ev;

    assign rise    = vsync_in & ~vs_q;
    assign in_win  = (span >= PW'(WIN_MIN_HL)) && (span <= PW'(WIN_MAX_HL));
    assign timeout = !rise && hl_tick && (span == PW'(WIN_MAX_HL));

    always_comb begin
        ev = EV_NONE;
        if (rise)
            ev = in_win ? EV_GOOD : EV_BAD;
        else if (timeout)
            ev = EV_BAD;
    end

    assign sync_hit = (ev == EV_GOOD) && locked;

    always_ff @(posedge clk) begin
        if (rst) begin
            vs_q <= 1'b0;
            span <= '0;
        end else begin
            vs_q <= vsync_in;
            if (rise || timeout)
                span <= '0;
            else if (hl_tick)
                span <= span + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            good_run <= '0;
            bad_run  <= '0;
            locked   <= 1'b0;
        end else begin
            case (ev)
                EV_GOOD: begin
                    bad_run <= '0;
                    if (good_run != LW'(LOCK_RUN))
                        good_run <= good_run + 1'b1;
                    if (run_next_full(int'(good_run), LOCK_RUN))
                        locked <= 1'b1;
                end
                EV_BAD: begin
                    good_run <= '0;
                    if (bad_run != LW'(LOCK_RUN))
                        bad_run <= bad_run + 1'b1;
                    if (run_next_full(int'(bad_run), LOCK_RUN))
                        locked <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    assert_span_cap_R4: assert property (@(posedge clk) disable iff (rst)
        span <= PW'(WIN_MAX_HL));

    assert_lock_on_good_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(ev == EV_GOOD));

    assert_lock_off_bad_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> $past(ev == EV_BAD));

    assert_runs_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
        !(good_run != '0 && bad_run != '0));
endmodule

// File: rtl/sg_field_count.sv
module sg_field_count
    import sgen_pkg::*;
#(
    parameter int unsigned FIELD_HL = DEF_FIELD_HL
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        hl_tick,
    input  logic                        sync_hit,
    output logic [$clog2(FIELD_HL)-1:0] vcnt
);
    localparam int unsigned VW = $clog2(FIELD_HL);

    always_ff @(posedge clk) begin
        if (rst)
            vcnt <= '0;
        else if (sync_hit)
            vcnt <= '0;
        else if (hl_tick)
            vcnt <= (vcnt == VW'(FIELD_HL - 1)) ? '0 : vcnt + 1'b1;
    end

    assert_vcnt_range_R2: assert property (@(posedge clk) disable iff (rst)
        vcnt < VW'(FIELD_HL));

    assert_snap_zero_R6: assert property (@(posedge clk) disable iff (rst)
        sync_hit |=> (vcnt == '0));

    assert_hold_no_tick_R10: assert property (@(posedge clk) disable iff (rst)
        (!sync_hit && !hl_tick) |=> $stable(vcnt));
endmodule

// File: rtl/sg_vdecode.sv
module sg_vdecode
    import sgen_pkg::*;
#(
    parameter int unsigned FIELD_HL      = DEF_FIELD_HL,
    parameter int unsigned VPULSE_LINES  = DEF_VPULSE_LINES,
    parameter int unsigned VBLANK_LINES  = DEF_VBLANK_LINES,
    parameter int unsigned POS_W         = DEF_POS_W
) (
    input  logic [$clog2(FIELD_HL)-1:0] vcnt,
    input  logic [POS_W-1:0]            vpos,
    input  logic                        service,
    output logic                        v_drive_n,
    output logic                        v_blank
);
    localparam int unsigned VW        = $clog2(FIELD_HL);
    localparam int unsigned VPULSE_HL = 2 * VPULSE_LINES;
    localparam int unsigned VBLANK_HL = 2 * VBLANK_LINES;

    logic [VW:0] shifted;

    generate
        if (POS_W == 0) begin : g_noshift
            assign shifted = {1'b0, vcnt};
        end else begin : g_shift
            logic [VW:0] off;
            assign off     = (VW + 1)'({vpos, 1'b0});
            assign shifted = ({1'b0, vcnt} >= off)
                           ? ({1'b0, vcnt} - off)
                           : ({1'b0, vcnt} + (VW + 1)'(FIELD_HL) - off);
        end
    endgenerate

    assign v_drive_n = service | (shifted >= (VW + 1)'(VPULSE_HL));
    assign v_blank   = (shifted < (VW + 1)'(VBLANK_HL));
endmodule

// File: rtl/countdown_sync_gen.sv
module countdown_sync_gen
    import sgen_pkg::*;
#(
    parameter int unsigned CLK_PER_LINE = DEF_CLK_PER_LINE,
    parameter int unsigned FIELD_HL     = DEF_FIELD_HL,
    parameter int unsigned VPULSE_LINES = DEF_VPULSE_LINES,
    parameter int unsigned VBLANK_LINES = DEF_VBLANK_LINES,
    parameter int unsigned POS_W        = DEF_POS_W,
    parameter int unsigned WIN_MIN_HL   = DEF_WIN_MIN_HL,
    parameter int unsigned WIN_MAX_HL   = DEF_WIN_MAX_HL,
    parameter int unsigned LOCK_RUN     = DEF_LOCK_RUN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             vsync_in,
    input  logic [POS_W-1:0] vpos,
    input  logic             service,
    output logic             h_drive,
    output logic             v_drive_n,
    output logic             v_blank,
    output logic             unlocked
);
    localparam int unsigned VW = $clog2(FIELD_HL);

    line_sig_t     line_s;
    logic          locked;
    logic          sync_hit;
    logic [VW-1:0] vcnt;

    sg_line_div #(.CLK_PER_LINE(CLK_PER_LINE)) u_line (
        .clk    (clk),
        .rst    (rst),
        .line_o (line_s)
    );

    sg_sync_qual #(
        .WIN_MIN_HL (WIN_MIN_HL),
        .WIN_MAX_HL (WIN_MAX_HL),
        .LOCK_RUN   (LOCK_RUN)
    ) u_qual (
        .clk      (clk),
        .rst      (rst),
        .vsync_in (vsync_in),
        .hl_tick  (line_s.hl_tick),
        .locked   (locked),
        .sync_hit (sync_hit)
    );

    sg_field_count #(.FIELD_HL(FIELD_HL)) u_field (
        .clk      (clk),
        .rst      (rst),
        .hl_tick  (line_s.hl_tick),
        .sync_hit (sync_hit),
        .vcnt     (vcnt)
    );

    sg_vdecode #(
        .FIELD_HL     (FIELD_HL),
        .VPULSE_LINES (VPULSE_LINES),
        .VBLANK_LINES (VBLANK_LINES),
        .POS_W        (POS_W)
    ) u_dec (
        .vcnt      (vcnt),
        .vpos      (vpos),
        .service   (service),
        .v_drive_n (v_drive_n),
        .v_blank   (v_blank)
    );

    assign h_drive  = line_s.h_hi;
    assign unlocked = ~locked;

    assert_pulse_in_blank_R7: assert property (@(posedge clk) disable iff (rst)
        !v_drive_n |-> v_blank);

    assert_service_idle_R9: assert property (@(posedge clk) disable iff (rst)
        service |-> v_drive_n);
endmodule

// File: tb/tb_countdown_sync_gen.sv
`timescale 1ns/100ps
module tb_countdown_sync_gen;
    localparam int CPL   = 8;
    localparam int HL    = CPL / 2;
    localparam int FIELD = 525;
    localparam int WMIN  = 492;
    localparam int WMAX  = 562;
    localparam int RUN   = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       vsync_in = 1'b0;
    logic [4:0] vpos = 5'd0;
    logic       service = 1'b0;
    logic       h_drive, v_drive_n, v_blank, unlocked;

    int vectors = 0;
    int errors  = 0;

    countdown_sync_gen #(.CLK_PER_LINE(CPL)) dut (
        .clk(clk), .rst(rst), .vsync_in(vsync_in), .vpos(vpos),
        .service(service), .h_drive(h_drive), .v_drive_n(v_drive_n),
        .v_blank(v_blank), .unlocked(unlocked)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference, updated at each rising edge
    int  m_clk_in_line, m_hl, m_since, m_good, m_bad;
    bit  m_lock, m_vs_prev;

    always @(posedge clk) begin
        bit tick, rise, good, bad;
        if (rst) begin
            m_clk_in_line = 0; m_hl = 0; m_since = 0;
            m_good = 0; m_bad = 0; m_lock = 0; m_vs_prev = 0;
        end else begin
            tick = ((m_clk_in_line % HL) == HL - 1);
            rise = vsync_in && !m_vs_prev;
            good = rise && (m_since >= WMIN) && (m_since <= WMAX);
            bad  = (rise && !good) || (!rise && tick && m_since == WMAX);
            if (good && m_lock) m_hl = 0;
            else if (tick)      m_hl = (m_hl + 1) % FIELD;
            if (rise || bad)    m_since = 0;
            else if (tick)      m_since++;
            if (good) begin
                m_bad = 0;
                if (m_good < RUN) m_good++;
                if (m_good >= RUN) m_lock = 1;
            end else if (bad) begin
                m_good = 0;
                if (m_bad < RUN) m_bad++;
                if (m_bad >= RUN) m_lock = 0;
            end
            m_clk_in_line = (m_clk_in_line + 1) % CPL;
            m_vs_prev = vsync_in;
        end
    end

    task automatic check(input string tag, input int got, input int exp);
        vectors++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Per-clock comparison, away from the active edge
    always @(posedge clk) begin
        #2;
        if (!rst) begin
            int s;
            s = (m_hl - 2 * int'(vpos) + FIELD) % FIELD;
            check("R1 h_drive", h_drive, (m_clk_in_line < HL) ? 1 : 0);
            check("R7 v_drive_n", v_drive_n, (service || s >= 20) ? 1 : 0);
            check("R7 v_blank", v_blank, (s < 34) ? 1 : 0);
            check("R5 unlocked", unlocked, m_lock ? 0 : 1);
        end
    end

    // One rising edge on vsync_in, hl half-lines after the previous one
    task automatic vs_edge(input int hl);
        repeat (hl * HL - 1) begin
            @(negedge clk); vsync_in = 1'b0;
        end
        @(negedge clk); vsync_in = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        int t0, t1, hi;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #1;
        // R11: state just after reset (first cycle out of reset)
        check("R11 h_drive", h_drive, 1);
        check("R11 v_drive_n", v_drive_n, 0);
        check("R11 v_blank", v_blank, 1);
        check("R11 unlocked", unlocked, 1);

        // R1: high clocks in one line
        @(negedge clk);
        while (h_drive) @(negedge clk);
        hi = 0;
        while (!h_drive) @(negedge clk);
        for (int i = 0; i < CPL; i++) begin
            if (h_drive) hi++;
            @(negedge clk);
        end
        check("R1 high clocks per line", hi, HL);

        // R2: free-run field period
        while (v_drive_n) @(negedge clk);
        while (!v_drive_n) @(negedge clk);
        while (v_drive_n) @(negedge clk);
        t0 = int'($time / 5);
        while (!v_drive_n) @(negedge clk);
        while (v_drive_n) @(negedge clk);
        t1 = int'($time / 5);
        check("R2 free-run period clocks", t1 - t0, FIELD * HL);

        // R3/R5: in-window sync pulls into lock
        for (int i = 0; i < 6; i++) vs_edge(500);
        @(posedge clk); #2;
        check("R5 locked after good run", unlocked, 0);
        check("R6 v_drive_n after snap", v_drive_n, 0);
        check("R6 v_blank after snap", v_blank, 1);

        // R8: shifted pulse stays inactive right after snap
        vpos = 5'd10;
        vs_edge(510);
        @(posedge clk); #2;
        check("R8 v_drive_n delayed", v_drive_n, 1);
        check("R8 v_blank delayed", v_blank, 0);
        vpos = 5'd31;
        vs_edge(520);
        vpos = 5'd0;

        // R9: service holds vertical drive idle for a whole field
        vs_edge(525);
        service = 1'b1;
        hi = 0;
        for (int i = 0; i < FIELD * HL; i++) begin
            @(negedge clk);
            if (!v_drive_n) hi++;
        end
        check("R9 low clocks in service", hi, 0);
        service = 1'b0;

        // R10/R3: out-of-window edges while locked neither snap nor keep lock
        vs_edge(WMIN - 80);
        @(posedge clk); #2;
        check("R10 no snap on bad edge", v_drive_n, 1);
        check("R5 still locked after one bad", unlocked, 0);
        for (int i = 0; i < 3; i++) vs_edge(400);
        @(posedge clk); #2;
        check("R5 unlocked after bad run", unlocked, 1);

        // R3: short by one half-line never locks
        for (int i = 0; i < 6; i++) vs_edge(WMIN - 1);
        @(posedge clk); #2;
        check("R3 below window stays unlocked", unlocked, 1);

        // R3: upper end of the window locks
        for (int i = 0; i < 6; i++) vs_edge(WMAX - 2);
        @(posedge clk); #2;
        check("R3 near upper limit locks", unlocked, 0);

        // R4: missing sync drops lock through timeouts
        @(negedge clk); vsync_in = 1'b0;
        repeat ((WMAX + 1) * HL * (RUN + 1)) @(negedge clk);
        check("R4 timeouts drop lock", unlocked, 1);

        // R3: lower end of the window locks again
        for (int i = 0; i < 6; i++) vs_edge(WMIN + 1);
        @(posedge clk); #2;
        check("R3 near lower limit locks", unlocked, 0);

        repeat (50) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule